// File: doc/BRIEF.md
# ROM Entry List Walker

This block walks the chain of variable-length entries that follows the 22-byte header of a device ROM image. The image sits in a byte memory with a one-cycle read latency. After a `start` pulse the walker reads the 10-bit payload length from header bytes 14 and 15, which are stored low byte first. It adds 13 to get the end of the image, then walks entry by entry from offset 22. Each entry gives its own size in its first byte, and the next entry starts that many bytes further on. The walker issues one byte read per cycle at most.

For each entry that passes the bounds checks, the walker emits one record on `rec_valid`. The record carries the entry's offset, length, index, disabled flag and type. For enabled port entries it also carries the link and dual-link fields. A broken chain stops the walk with `walk_err` and a cause code. A clean walk ends with `walk_done`. The consumer acts on the records as they arrive. This block does not act on the ports.

Control states and transitions:
- IDLE goes to SZ_LO on `start`.
- SZ_LO goes to SZ_HI.
- SZ_HI goes to CHECK.
- CHECK goes to DONE at the end of the image, to FAIL on a lone trailing byte, and otherwise to LEN.
- LEN goes to FAIL on a zero length or an overrun, and otherwise to HDR.
- HDR goes to B2 for an enabled port entry of the correct size, and otherwise to EMIT.
- B2 goes to B3, and B3 goes to EMIT.
- EMIT goes back to CHECK.
- DONE and FAIL each go to IDLE.

Top module: `rom_entry_walker`

## Requirements
- R1: On `start` the walker reads image bytes 14 (low) and 15 (high). The end offset is ({byte15[1:0], byte14}) + 13, and bits 7:2 of byte 15 are ignored. The walk begins at offset 22.
- R2: If an entry would begin exactly one byte before the end offset, the walk stops with `walk_err` and `err_code` = 1. No record is emitted for that byte.
- R3: An entry whose length byte (entry byte 0) is zero stops the walk with `walk_err` and `err_code` = 2. No record is emitted for it.
- R4: An entry whose offset plus length exceeds the end offset stops the walk with `walk_err` and `err_code` = 3. No record is emitted for it.
- R5: When the next entry offset is at or beyond the end offset, `walk_done` pulses for one cycle. An entry that ends exactly at the end offset is accepted. An image whose end offset is 22 or less finishes with no records.
- R6: Each accepted entry produces exactly one `rec_valid` pulse with the following fields:
  - `rec_offset` is the entry's offset and `rec_len` is its byte 0.
  - From entry byte 1: `rec_index` = bits 5:0, `rec_disabled` = bit 6, `rec_is_port` = bit 7 (1 = port, 0 = generic).
  - The next entry starts at offset + length.
- R7: For a port entry that is not disabled and has length 8, the port fields come from entry bytes 2 and 3:
  - `rec_dual_rid` = byte2[3:0], `rec_link` = byte2[4] and `rec_has_dual` = byte2[7].
  - `rec_dual_nr` = byte3[5:0].
- R8: A port entry that is not disabled and has a length other than 8 reports `rec_size_err` = 1 with all port fields zero. The walk then continues.
- R9: For generic entries and disabled port entries, the content of bytes 2 and 3 has no effect. Their port fields are zero and `rec_size_err` is 0 whatever their length.
- R10: At most one of `rec_valid`, `walk_done` and `walk_err` is high in any cycle. `walk_done` and `walk_err` are single-cycle pulses. A `start` during a walk is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (only acted on when idle) |
| mem_rd_en | output | 1 | Byte read request |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_rd_data | input | 8 | Read data, one cycle after the request |
| rec_valid | output | 1 | Record strobe |
| rec_offset | output | ADDR_W | Offset of the entry |
| rec_len | output | 8 | Entry length byte |
| rec_index | output | 6 | Entry index |
| rec_disabled | output | 1 | Port-disabled flag |
| rec_is_port | output | 1 | Entry type is port |
| rec_size_err | output | 1 | Enabled port entry of wrong size |
| rec_link | output | 1 | Link number |
| rec_dual_rid | output | 4 | Dual-link partner field |
| rec_has_dual | output | 1 | Dual-link partner present |
| rec_dual_nr | output | 6 | Dual-link port number |
| walk_done | output | 1 | Walk finished normally |
| walk_err | output | 1 | Walk aborted |
| err_code | output | 2 | Abort cause: 1 lone byte, 2 zero length, 3 overrun |

## Verification
Two decisions meet at the same offset: the end-of-image test and the bounds test on the entry that might start there. One image places the last entry so that it ends exactly on the end offset, which must give a record followed by `walk_done` and no overrun. Another leaves a single byte after the last entry, which must give `walk_err` with cause 1 and no extra record. The bench also pulses `start` in the middle of a walk and checks every cycle that record, done and error strobes never coincide.

// File: rtl/rew_pkg.sv
package rew_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SZ_LO,
        ST_SZ_HI,
        ST_CHECK,
        ST_LEN,
        ST_HDR,
        ST_B2,
        ST_B3,
        ST_EMIT,
        ST_DONE,
        ST_FAIL
    } walk_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_TAIL = 2'd1,
        CAUSE_ZERO = 2'd2,
        CAUSE_OVER = 2'd3
    } walk_cause_e;

    typedef struct packed {
        logic [5:0] index;
        logic       disabled;
        logic       is_port;
        logic       size_err;
        logic       link;
        logic       has_dual;
        logic [3:0] dual_rid;
        logic [5:0] dual_nr;
    } entry_rec_t;

endpackage

// File: rtl/walk_bounds.sv
module walk_bounds #(
    parameter int POS_W = 12
) (
    input  logic [POS_W-1:0] pos,
    input  logic [POS_W-1:0] end_pos,
    input  logic [7:0]       len,
    output logic             at_end,
    output logic             lone_tail,
    output logic             len_zero,
    output logic             overrun
);
    localparam int SUM_W = POS_W + 1;

    logic [SUM_W-1:0] next_one;
    logic [SUM_W-1:0] next_ent;
    logic [SUM_W-1:0] end_ext;

    always_comb begin
        end_ext   = {1'b0, end_pos};
        next_one  = {1'b0, pos} + SUM_W'(1);
        next_ent  = {1'b0, pos} + SUM_W'(len);
        at_end    = (pos >= end_pos);
        lone_tail = (next_one == end_ext);
        len_zero  = (len == 8'd0);
        overrun   = (next_ent > end_ext);
    end
endmodule

// File: rtl/entry_fields.sv
module entry_fields
    import rew_pkg::*;
#(
    parameter int PORT_LEN = 8
) (
    input  logic [7:0] hdr,
    input  logic [7:0] len,
    input  logic [5:0] b2_keep,
    input  logic [5:0] b3_nr,
    output entry_rec_t rec,
    output logic       needs_detail
);
    logic take;

    always_comb begin
        needs_detail = hdr[7] && !hdr[6];
        rec.index    = hdr[5:0];
        rec.disabled = hdr[6];
        rec.is_port  = hdr[7];
        rec.size_err = needs_detail && (len != 8'(PORT_LEN));
        take         = needs_detail && !rec.size_err;
        rec.has_dual = take && b2_keep[5];
        rec.link     = take && b2_keep[4];
        rec.dual_rid = take ? b2_keep[3:0] : 4'd0;
        rec.dual_nr  = take ? b3_nr : 6'd0;
    end
endmodule

// File: rtl/walker_fsm.sv
module walker_fsm
    import rew_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int PAY_W    = 10,
    parameter int SIZE_OFF = 14,
    parameter int HDR_LEN  = 22,
    parameter int BASE_ADD = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rd_data,
    output logic [ADDR_W:0]   pos_q,
    output logic [ADDR_W:0]   end_q,
    output logic [7:0]        len_cur,
    output logic [7:0]        hdr_cur,
    output logic [5:0]        b2_keep_q,
    output logic [5:0]        b3_nr_q,
    input  logic              at_end,
    input  logic              lone_tail,
    input  logic              len_zero,
    input  logic              overrun,
    input  logic              needs_detail,
    input  logic              size_bad,
    output logic              rec_valid,
    output logic              walk_done,
    output logic              walk_err,
    output logic [1:0]        err_code
);
    localparam int POS_W = ADDR_W + 1;

    walk_state_e state_q, state_d;
    logic [7:0]  size_lo_q;
    logic [7:0]  len_q;
    logic [7:0]  hdr_q;
    walk_cause_e cause_q;

    always_comb begin
        len_cur = (state_q == ST_LEN) ? mem_rd_data : len_q;
        hdr_cur = (state_q == ST_HDR) ? mem_rd_data : hdr_q;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_SZ_LO;
            ST_SZ_LO: state_d = ST_SZ_HI;
            ST_SZ_HI: state_d = ST_CHECK;
            ST_CHECK: begin
                if (at_end)         state_d = ST_DONE;
                else if (lone_tail) state_d = ST_FAIL;
                else                state_d = ST_LEN;
            end
            ST_LEN: begin
                if (len_zero || overrun) state_d = ST_FAIL;
                else                     state_d = ST_HDR;
            end
            ST_HDR: begin
                if (needs_detail && !size_bad) state_d = ST_B2;
                else                           state_d = ST_EMIT;
            end
            ST_B2:   state_d = ST_B3;
            ST_B3:   state_d = ST_EMIT;
            ST_EMIT: state_d = ST_CHECK;
            ST_DONE: state_d = ST_IDLE;
            ST_FAIL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q     <= '0;
            end_q     <= '0;
            size_lo_q <= '0;
            len_q     <= '0;
            hdr_q     <= '0;
            b2_keep_q <= '0;
            b3_nr_q   <= '0;
            cause_q   <= CAUSE_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) cause_q <= CAUSE_NONE;
                ST_SZ_LO: size_lo_q <= mem_rd_data;
                ST_SZ_HI: begin
                    end_q <= POS_W'({mem_rd_data[PAY_W-9:0], size_lo_q}) + POS_W'(BASE_ADD);
                    pos_q <= POS_W'(HDR_LEN);
                end
                ST_CHECK: if (!at_end && lone_tail) cause_q <= CAUSE_TAIL;
                ST_LEN: begin
                    len_q     <= mem_rd_data;
                    b2_keep_q <= '0;
                    b3_nr_q   <= '0;
                    if (len_zero)     cause_q <= CAUSE_ZERO;
                    else if (overrun) cause_q <= CAUSE_OVER;
                end
                ST_HDR:  hdr_q     <= mem_rd_data;
                ST_B2:   b2_keep_q <= {mem_rd_data[7], mem_rd_data[4:0]};
                ST_B3:   b3_nr_q   <= mem_rd_data[5:0];
                ST_EMIT: pos_q     <= pos_q + POS_W'(len_q);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_rd_en = 1'b0;
        mem_addr  = '0;
        rec_valid = (state_q == ST_EMIT);
        walk_done = (state_q == ST_DONE);
        walk_err  = (state_q == ST_FAIL);
        err_code  = cause_q;
        unique case (state_q)
            ST_IDLE: begin
                mem_rd_en = start;
                mem_addr  = ADDR_W'(SIZE_OFF);
            end
            ST_SZ_LO: begin
                mem_rd_en = 1'b1;
                mem_addr  = ADDR_W'(SIZE_OFF + 1);
            end
            ST_CHECK: begin
                mem_rd_en = !at_end && !lone_tail;
                mem_addr  = ADDR_W'(pos_q);
            end
            ST_LEN: begin
                mem_rd_en = !len_zero && !overrun;
                mem_addr  = ADDR_W'(pos_q + POS_W'(1));
            end
            ST_HDR: begin
                mem_rd_en = needs_detail && !size_bad;
                mem_addr  = ADDR_W'(pos_q + POS_W'(2));
            end
            ST_B2: begin
                mem_rd_en = 1'b1;
                mem_addr  = ADDR_W'(pos_q + POS_W'(3));
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rom_entry_walker.sv
module rom_entry_walker
    import rew_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int PAY_W    = 10,
    parameter int SIZE_OFF = 14,
    parameter int HDR_LEN  = 22,
    parameter int BASE_ADD = 13,
    parameter int PORT_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              rec_valid,
    output logic [ADDR_W-1:0] rec_offset,
    output logic [7:0]        rec_len,
    output logic [5:0]        rec_index,
    output logic              rec_disabled,
    output logic              rec_is_port,
    output logic              rec_size_err,
    output logic              rec_link,
    output logic [3:0]        rec_dual_rid,
    output logic              rec_has_dual,
    output logic [5:0]        rec_dual_nr,
    output logic              walk_done,
    output logic              walk_err,
    output logic [1:0]        err_code
);
    localparam int POS_W = ADDR_W + 1;

    logic [POS_W-1:0] pos_q, end_q;
    logic [7:0]       len_cur, hdr_cur;
    logic [5:0]       b2_keep_q, b3_nr_q;
    logic             at_end, lone_tail, len_zero, overrun;
    logic             needs_detail;
    entry_rec_t       rec;

    walker_fsm #(
        .ADDR_W(ADDR_W), .PAY_W(PAY_W), .SIZE_OFF(SIZE_OFF),
        .HDR_LEN(HDR_LEN), .BASE_ADD(BASE_ADD)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
        .pos_q(pos_q), .end_q(end_q), .len_cur(len_cur), .hdr_cur(hdr_cur),
        .b2_keep_q(b2_keep_q), .b3_nr_q(b3_nr_q),
        .at_end(at_end), .lone_tail(lone_tail), .len_zero(len_zero), .overrun(overrun),
        .needs_detail(needs_detail), .size_bad(rec.size_err),
        .rec_valid(rec_valid), .walk_done(walk_done), .walk_err(walk_err),
        .err_code(err_code)
    );

    walk_bounds #(.POS_W(POS_W)) u_bounds (
        .pos(pos_q), .end_pos(end_q), .len(len_cur),
        .at_end(at_end), .lone_tail(lone_tail), .len_zero(len_zero), .overrun(overrun)
    );

    entry_fields #(.PORT_LEN(PORT_LEN)) u_fields (
        .hdr(hdr_cur), .len(len_cur), .b2_keep(b2_keep_q), .b3_nr(b3_nr_q),
        .rec(rec), .needs_detail(needs_detail)
    );

    always_comb begin
        rec_offset   = pos_q[ADDR_W-1:0];
        rec_len      = len_cur;
        rec_index    = rec.index;
        rec_disabled = rec.disabled;
        rec_is_port  = rec.is_port;
        rec_size_err = rec.size_err;
        rec_link     = rec.link;
        rec_dual_rid = rec.dual_rid;
        rec_has_dual = rec.has_dual;
        rec_dual_nr  = rec.dual_nr;
    end
endmodule

// File: rtl/rew_checker.sv
module rew_checker #(
    parameter int PORT_LEN = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rec_valid,
    input logic [7:0] rec_len,
    input logic       rec_disabled,
    input logic       rec_is_port,
    input logic       rec_size_err,
    input logic       rec_link,
    input logic [3:0] rec_dual_rid,
    input logic       rec_has_dual,
    input logic [5:0] rec_dual_nr,
    input logic       walk_done,
    input logic       walk_err,
    input logic [1:0] err_code
);
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rec_valid, walk_done, walk_err})); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !walk_done); // R5

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_err |=> !walk_err); // R10

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        walk_err |-> err_code != 2'd0); // R2

    AST_REC_LEN_NZ: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid |-> rec_len != 8'd0); // R3

    AST_SIZE_ERR_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && rec_size_err) |-> (rec_is_port && !rec_disabled && rec_len != 8'(PORT_LEN))); // R8

    AST_SKIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && (!rec_is_port || rec_disabled)) |->
        (!rec_link && !rec_has_dual && rec_dual_rid == 4'd0 && rec_dual_nr == 6'd0 && !rec_size_err)); // R9
endmodule

bind rom_entry_walker rew_checker #(.PORT_LEN(PORT_LEN)) u_rew_checker (
    .clk(clk), .rst_n(rst_n), .rec_valid(rec_valid), .rec_len(rec_len),
    .rec_disabled(rec_disabled), .rec_is_port(rec_is_port), .rec_size_err(rec_size_err),
    .rec_link(rec_link), .rec_dual_rid(rec_dual_rid), .rec_has_dual(rec_has_dual),
    .rec_dual_nr(rec_dual_nr), .walk_done(walk_done), .walk_err(walk_err),
    .err_code(err_code)
);

// File: tb/tb_rom_entry_walker.sv
module tb_rom_entry_walker;
    localparam int ADDR_W = 11;
    localparam int MEM_N  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mem_rd_en;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_rd_data = 8'd0;
    logic rec_valid, rec_disabled, rec_is_port, rec_size_err, rec_link, rec_has_dual;
    logic [ADDR_W-1:0] rec_offset;
    logic [7:0] rec_len;
    logic [5:0] rec_index, rec_dual_nr;
    logic [3:0] rec_dual_rid;
    logic walk_done, walk_err;
    logic [1:0] err_code;

    logic [7:0] mem [0:MEM_N-1];

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int n_rec;
    int r_off [0:15], r_len [0:15], r_idx [0:15], r_dis [0:15], r_port [0:15];
    int r_sz [0:15], r_link [0:15], r_rid [0:15], r_hd [0:15], r_nr [0:15];
    bit got_done, got_err, multi_evt;
    int got_code, n_done, n_err;

    always #5 clk = ~clk;

    rom_entry_walker dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rd_data(mem_rd_data),
        .rec_valid(rec_valid), .rec_offset(rec_offset), .rec_len(rec_len),
        .rec_index(rec_index), .rec_disabled(rec_disabled), .rec_is_port(rec_is_port),
        .rec_size_err(rec_size_err), .rec_link(rec_link), .rec_dual_rid(rec_dual_rid),
        .rec_has_dual(rec_has_dual), .rec_dual_nr(rec_dual_nr),
        .walk_done(walk_done), .walk_err(walk_err), .err_code(err_code)
    );

    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_addr];
    end

    // capture monitor, sampled after the edge has settled
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (int'(rec_valid) + int'(walk_done) + int'(walk_err) > 1) multi_evt = 1'b1;
            if (rec_valid && n_rec < 16) begin
                r_off[n_rec] = int'(rec_offset);  r_len[n_rec] = int'(rec_len);
                r_idx[n_rec] = int'(rec_index);   r_dis[n_rec] = int'(rec_disabled);
                r_port[n_rec] = int'(rec_is_port); r_sz[n_rec] = int'(rec_size_err);
                r_link[n_rec] = int'(rec_link);   r_rid[n_rec] = int'(rec_dual_rid);
                r_hd[n_rec] = int'(rec_has_dual); r_nr[n_rec] = int'(rec_dual_nr);
                n_rec++;
            end
            if (walk_done) begin got_done = 1'b1; n_done++; end
            if (walk_err) begin got_err = 1'b1; n_err++; got_code = int'(err_code); end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual cycles %0d expected below 150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic clear_image(input int payload, input int hi_junk);
        for (int i = 0; i < MEM_N; i++) mem[i] = 8'hEE;
        mem[14] = 8'(payload & 255);
        mem[15] = 8'(((payload >> 8) & 3) | (hi_junk << 2));
    endtask

    task automatic run_walk(input bit restart);
        n_rec = 0; got_done = 0; got_err = 0; got_code = 0;
        n_done = 0; n_err = 0; multi_evt = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (restart) begin
            repeat (6) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        for (int k = 0; k < 5000 && !got_done && !got_err; k++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk_eq("R10 coinciding strobes", int'(multi_evt), 0);
    endtask

    task automatic t_reset();
        chk_eq("R10 reset rec_valid", int'(rec_valid), 0);
        chk_eq("R10 reset walk_done", int'(walk_done), 0);
        chk_eq("R10 reset walk_err", int'(walk_err), 0);
        chk_eq("R1 reset mem_rd_en", int'(mem_rd_en), 0);
    endtask

    task automatic t_empty();
        clear_image(9, 0); // end = 22
        run_walk(1'b0);
        chk_eq("R5 empty done", int'(got_done), 1);
        chk_eq("R5 empty records", n_rec, 0);
        chk_eq("R5 empty no err", int'(got_err), 0);
    endtask

    task automatic t_mixed(input bit restart);
        clear_image(32, 0); // end = 45
        mem[22] = 8'd4; mem[23] = 8'h03; mem[24] = 8'hFF; mem[25] = 8'hFF;
        mem[26] = 8'd8; mem[27] = 8'h81; mem[28] = 8'h9A; mem[29] = 8'h05;
        mem[34] = 8'd5; mem[35] = 8'hC2; mem[36] = 8'hFF; mem[37] = 8'hFF;
        mem[39] = 8'd6; mem[40] = 8'h84; mem[41] = 8'hFF; mem[42] = 8'hFF;
        run_walk(restart);
        chk_eq("R6 record count", n_rec, 4);
        chk_eq("R10 one done", n_done, 1);
        chk_eq("R6 offsets", r_off[0] + 100 * r_off[1], 22 + 100 * 26);
        chk_eq("R6 offsets late", r_off[2] + 100 * r_off[3], 34 + 100 * 39);
        chk_eq("R6 generic index", r_idx[0], 3);
        chk_eq("R6 generic type", r_port[0], 0);
        chk_eq("R9 generic fields", r_link[0] + r_rid[0] + r_hd[0] + r_nr[0] + r_sz[0], 0);
        chk_eq("R7 port rid", r_rid[1], 10);
        chk_eq("R7 port link", r_link[1], 1);
        chk_eq("R7 port has_dual", r_hd[1], 1);
        chk_eq("R7 port dual_nr", r_nr[1], 5);
        chk_eq("R7 port no size err", r_sz[1], 0);
        chk_eq("R6 disabled flag", r_dis[2], 1);
        chk_eq("R9 disabled fields", r_link[2] + r_rid[2] + r_hd[2] + r_nr[2] + r_sz[2], 0);
        chk_eq("R8 size err", r_sz[3], 1);
        chk_eq("R8 size err fields", r_link[3] + r_rid[3] + r_hd[3] + r_nr[3], 0);
        chk_eq("R6 index of last", r_idx[3], 4);
    endtask

    task automatic t_zero();
        clear_image(17, 0); // end = 30
        mem[22] = 8'd4; mem[23] = 8'h01;
        mem[26] = 8'd0;
        run_walk(1'b0);
        chk_eq("R3 records before zero", n_rec, 1);
        chk_eq("R3 err", int'(got_err), 1);
        chk_eq("R3 code", got_code, 2);
    endtask

    task automatic t_over();
        clear_image(15, 0); // end = 28
        mem[22] = 8'd10; mem[23] = 8'h00;
        run_walk(1'b0);
        chk_eq("R4 records", n_rec, 0);
        chk_eq("R4 code", got_code, 3);
        chk_eq("R4 no done", int'(got_done), 0);
    endtask

    task automatic t_tail();
        clear_image(14, 0); // end = 27
        mem[22] = 8'd4; mem[23] = 8'h02;
        mem[26] = 8'd1;
        run_walk(1'b0);
        chk_eq("R2 records", n_rec, 1);
        chk_eq("R2 code", got_code, 1);
        chk_eq("R2 err", int'(got_err), 1);
    endtask

    task automatic t_exact();
        clear_image(17, 0); // end = 30
        mem[22] = 8'd8; mem[23] = 8'h87; mem[24] = 8'h10; mem[25] = 8'h3F;
        run_walk(1'b0);
        chk_eq("R5 exact fit records", n_rec, 1);
        chk_eq("R5 exact fit done", int'(got_done), 1);
        chk_eq("R5 exact fit no err", int'(got_err), 0);
        chk_eq("R7 exact link", r_link[0], 1);
        chk_eq("R7 exact dual_nr", r_nr[0], 63);
    endtask

    task automatic t_size_field();
        clear_image(256, 63); // end = 269, junk in byte 15 bits 7:2
        mem[22] = 8'd247; mem[23] = 8'h05;
        mem[269] = 8'd0;
        run_walk(1'b0);
        chk_eq("R1 records", n_rec, 1);
        chk_eq("R1 length", r_len[0], 247);
        chk_eq("R1 done", int'(got_done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_empty();
        t_mixed(1'b0);
        t_mixed(1'b1); // R10 start during walk is ignored
        t_zero();
        t_over();
        t_tail();
        t_exact();
        t_size_field();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule